// File: doc/BRIEF.md
# Dual-Mode Serial Baud Generator

This block produces the timing reference for a serial port that can run either asynchronously or as a synchronous master. A free-running down counter is reloaded from a divisor that software writes one byte at a time (low byte and high byte, through a shared data bus with two write strobes). Each reload gives a one-cycle sample tick. A prescaler counts these sample ticks and gives a one-cycle bit tick once per bit period. In synchronous mode it also drives a shift clock with a 50% duty cycle.

Three level inputs set the operating mode. The first selects 8-bit or 16-bit divisor width. The second selects fast sampling. The third selects synchronous mode. Together they choose how many sample ticks make one bit. Any change to the divisor, and any change to a mode input that affects timing, restarts the counter and the prescaler from a clean state. The new rate therefore applies at once, without waiting for the old period to finish. The block holds no shift registers. It only supplies the ticks and the clock that those registers use.

Top module: `baud_gen`

## Requirements
- R1: While reset is asserted all three outputs are low. After release both divisor bytes are zero and the mode is asynchronous 8-bit slow. The first sample tick is high in the cycle after the first clock edge, and sample ticks then repeat every cycle.
- R2: The sample tick is one cycle wide and repeats every D+1 cycles. D is {high,low} when the 16-bit select is 1. D is the low byte alone when the select is 0, and in that case the high byte has no effect on timing.
- R3: In asynchronous mode a bit spans P sample ticks. P is 64 when both the 16-bit and fast selects are 0, 16 when exactly one of them is 1, and 4 when both are 1.
- R4: In synchronous mode P is 4 whatever the fast select is. A change of the fast select while in synchronous mode does not disturb the tick schedule.
- R5: The bit tick is one cycle wide. It is high in the cycle after the P-th sample tick that follows a restart, and then every P*(D+1) cycles.
- R6: A write strobe on either divisor byte restarts the block at that clock edge. No sample tick appears in the following cycle, and the first sample tick comes one cycle later. This holds even when the write lands on the edge where the counter would have reloaded.
- R7: A change of the synchronous select, of the 16-bit select, or of the fast select in asynchronous mode restarts the block with the same timing as a divisor write.
- R8: In synchronous mode the shift clock is low after a restart. It rises in the cycle after the 2nd sample tick and falls together with the bit tick, so it toggles every half bit period. In asynchronous mode it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_i | input | 1 | 1 = 16-bit divisor, 0 = low byte only |
| fast_i | input | 1 | Fast sampling select (asynchronous mode only) |
| sync_i | input | 1 | 1 = synchronous master mode |
| lo_wr_i | input | 1 | Write strobe for the divisor low byte |
| hi_wr_i | input | 1 | Write strobe for the divisor high byte |
| wdata_i | input | 8 | Divisor byte data |
| sample_tick_o | output | 1 | One-cycle pulse on each counter reload |
| bit_tick_o | output | 1 | One-cycle pulse once per bit period |
| sclk_o | output | 1 | Shift clock in synchronous mode, low otherwise |

## Verification
A restart (a divisor write or a mode change) and a counter reload can fall on the same clock edge. The restart must win: the reload tick is suppressed and a fresh schedule begins. The bench predicts the reload edge from the known divisor and places a low-byte write strobe exactly on it. It then requires no sample tick in the next cycle, the first tick one cycle later, and bit ticks and shift-clock edges at the positions computed from the restart. Random and directed mode/divisor combinations check the periods. A mid-run flip of the fast select in synchronous mode shows that this input is ignored.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    // Operating mode as seen by the timing logic; fast is already masked
    // off in synchronous mode so that it cannot cause a restart there.
    typedef struct packed {
        logic sync;
        logic wide;
        logic fast;
    } mode_t;

endpackage

// File: rtl/baud_mode_track.sv
module baud_mode_track
    import baud_gen_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sync_i,
    input  logic  wide_i,
    input  logic  fast_i,
    output mode_t mode_o,
    output logic  changed_o
);

    typedef struct packed {
        mode_t mode;
    } state_t;

    state_t st_d, st_q;
    mode_t  mode_now;

    always_comb begin
        mode_now.sync = sync_i;
        mode_now.wide = wide_i;
        mode_now.fast = fast_i & ~sync_i;
        st_d          = st_q;
        st_d.mode     = mode_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.mode;
    assign changed_o = (mode_now != st_q.mode);

    AST_FAST_MASKED_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode.sync |-> !st_q.mode.fast) else $error("fast kept in sync mode"); // R4

endmodule

// File: rtl/baud_divisor.sv
module baud_divisor #(
    parameter int BYTE_W = 8,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_wr_i,
    input  logic              hi_wr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              wide_i,
    output logic [DIV_W-1:0]  div_o,
    output logic              wrote_o
);

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lo_wr_i) begin
            st_d.lo = wdata_i;
        end
        if (hi_wr_i) begin
            st_d.hi = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (wide_i) begin
            div_o = {st_q.hi, st_q.lo};
        end else begin
            div_o = {{BYTE_W{1'b0}}, st_q.lo};
        end
    end

    assign wrote_o = lo_wr_i | hi_wr_i;

    AST_LO_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr_i |=> (div_o[BYTE_W-1:0] == $past(wdata_i))) else $error("low byte lost"); // R2

endmodule

// File: rtl/baud_counter.sv
module baud_counter #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b0;
        end else if (st_q.cnt == '0) begin
            st_d.cnt  = div_i;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt - 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    AST_CNT_WITHIN_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= div_i) else $error("counter above divisor"); // R2

    AST_RESTART_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!st_q.tick && st_q.cnt == '0)) else $error("restart not clean"); // R6

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_gen_pkg::*;
#(
    parameter int PRE_SLOW = 64,
    parameter int PRE_MID  = 16,
    parameter int PRE_FAST = 4,
    localparam int PRE_W   = $clog2(PRE_SLOW)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart_i,
    input  logic  tick_i,
    input  mode_t mode_i,
    output logic  bit_o,
    output logic  sclk_o
);

    localparam logic [PRE_W:0] SC_SLOW = (PRE_W + 1)'(PRE_SLOW);
    localparam logic [PRE_W:0] SC_MID  = (PRE_W + 1)'(PRE_MID);
    localparam logic [PRE_W:0] SC_FAST = (PRE_W + 1)'(PRE_FAST);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             bitp;
        logic             sclk;
    } state_t;

    state_t st_d, st_q;
    logic [PRE_W:0] scale;
    logic [PRE_W:0] pre_ext;
    logic           at_end;
    logic           at_half;

    always_comb begin
        if (mode_i.sync) begin
            scale = SC_FAST;
        end else begin
            unique case ({mode_i.wide, mode_i.fast})
                2'b00:   scale = SC_SLOW;
                2'b11:   scale = SC_FAST;
                default: scale = SC_MID;
            endcase
        end
    end

    assign pre_ext = {1'b0, st_q.pre};
    assign at_end  = (pre_ext == scale - 1'b1);
    assign at_half = (pre_ext == (scale >> 1) - 1'b1);

    always_comb begin
        st_d      = st_q;
        st_d.bitp = 1'b0;
        if (restart_i) begin
            st_d.pre  = '0;
            st_d.sclk = 1'b0;
        end else if (tick_i) begin
            if (at_end) begin
                st_d.pre  = '0;
                st_d.bitp = 1'b1;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
            if (mode_i.sync && (at_end || at_half)) begin
                st_d.sclk = ~st_q.sclk;
            end
        end
        if (!mode_i.sync) begin
            st_d.sclk = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o  = st_q.bitp;
    assign sclk_o = st_q.sclk;

    AST_PRE_BELOW_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_ext < scale) else $error("prescaler past its scale"); // R3

    AST_BIT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bitp |-> $past(tick_i)) else $error("bit tick without sample tick"); // R5

    AST_SCLK_LOW_ASYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i.sync |-> !st_q.sclk) else $error("shift clock in async mode"); // R8

    AST_SCLK_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sclk != $past(st_q.sclk)) |-> ($past(tick_i) || $past(restart_i)))
        else $error("shift clock moved off a tick"); // R8

endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_gen_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int PRE_SLOW = 64,
    parameter int PRE_MID  = 16,
    parameter int PRE_FAST = 4,
    localparam int DIV_W   = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_i,
    input  logic              fast_i,
    input  logic              sync_i,
    input  logic              lo_wr_i,
    input  logic              hi_wr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic              sample_tick_o,
    output logic              bit_tick_o,
    output logic              sclk_o
);

    mode_t            mode_q;
    logic             mode_chg;
    logic [DIV_W-1:0] div;
    logic             wrote;
    logic             restart;
    logic             tick;

    baud_mode_track u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (sync_i),
        .wide_i    (wide_i),
        .fast_i    (fast_i),
        .mode_o    (mode_q),
        .changed_o (mode_chg)
    );

    baud_divisor #(.BYTE_W(BYTE_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_wr_i (lo_wr_i),
        .hi_wr_i (hi_wr_i),
        .wdata_i (wdata_i),
        .wide_i  (mode_q.wide),
        .div_o   (div),
        .wrote_o (wrote)
    );

    assign restart = wrote | mode_chg;

    baud_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .div_i     (div),
        .tick_o    (tick)
    );

    baud_prescaler #(
        .PRE_SLOW (PRE_SLOW),
        .PRE_MID  (PRE_MID),
        .PRE_FAST (PRE_FAST)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .tick_i    (tick),
        .mode_i    (mode_q),
        .bit_o     (bit_tick_o),
        .sclk_o    (sclk_o)
    );

    assign sample_tick_o = tick;

    AST_WRITE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr_i || hi_wr_i) |=> !sample_tick_o) else $error("tick right after write"); // R6

    AST_BIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |=> !bit_tick_o) else $error("bit tick wider than one cycle"); // R5

endmodule

// File: tb/baud_gen_test.sv
`timescale 1ns/1ps
module baud_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wide_i = 1'b0, fast_i = 1'b0, sync_i = 1'b0;
    logic       lo_wr_i = 1'b0, hi_wr_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic       sample_tick_o, bit_tick_o, sclk_o;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    baud_gen uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wide_i        (wide_i),
        .fast_i        (fast_i),
        .sync_i        (sync_i),
        .lo_wr_i       (lo_wr_i),
        .hi_wr_i       (hi_wr_i),
        .wdata_i       (wdata_i),
        .sample_tick_o (sample_tick_o),
        .bit_tick_o    (bit_tick_o),
        .sclk_o        (sclk_o)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        if (cyc > 190000 && !done) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual cycle %0d expected below 190000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Ticks per bit from R3/R4.
    function automatic int exp_scale(bit s, bit w, bit f);
        if (s) return 4;
        if (!w && !f) return 64;
        if (w && f) return 4;
        return 16;
    endfunction

    function automatic int exp_div(bit w, int hi, int lo);
        return w ? (hi * 256 + lo) : lo;
    endfunction

    // Program mode then both bytes; returns the edge index of the last write.
    task automatic config_run(bit s, bit w, bit f, int hi, int lo, output int ref_c);
        @(negedge clk);
        sync_i = s; wide_i = w; fast_i = f;
        @(negedge clk);
        hi_wr_i = 1'b1; wdata_i = 8'(hi);
        @(negedge clk);
        hi_wr_i = 1'b0; lo_wr_i = 1'b1; wdata_i = 8'(lo);
        @(negedge clk);
        lo_wr_i = 1'b0;
        ref_c = cyc;
    endtask

    // Called at the negedge right after the restart edge ref_c.
    task automatic measure(string rtag, string ptag, int d, int p, bit is_sync,
                           int ref_c, bit flip);
        int  t1 = -1, t2 = -1, b1 = -1, b2 = -1, sr = -1, sf = -1;
        bit  prev_s = 0;
        bit  async_high = 0;
        int  limit = ref_c + 3 * p * (d + 1) + 20;
        while (cyc <= limit && b2 < 0) begin
            if (sample_tick_o) begin
                if (t1 < 0) t1 = cyc;
                else if (t2 < 0) t2 = cyc;
            end
            if (bit_tick_o) begin
                if (b1 < 0) b1 = cyc;
                else if (b2 < 0) b2 = cyc;
            end
            if (sclk_o && !prev_s && sr < 0) sr = cyc;
            if (!sclk_o && prev_s && sr >= 0 && sf < 0) sf = cyc;
            if (sclk_o && !is_sync) async_high = 1;
            prev_s = sclk_o;
            if (flip && cyc == ref_c + 3) fast_i = ~fast_i;
            @(negedge clk);
        end
        chk(rtag, "first sample tick", t1, ref_c + 1);
        chk("R2", "second sample tick", t2, ref_c + 2 + d);
        chk("R5", "first bit tick", b1, ref_c + 2 + (d + 1) * (p - 1));
        chk(ptag, "bit period", b2 - b1, p * (d + 1));
        if (is_sync) begin
            chk("R8", "sclk rise", sr, ref_c + 2 + (d + 1));
            chk("R8", "sclk fall", sf, b1);
        end else begin
            chk("R8", "sclk high in async", int'(async_high), 0);
        end
    endtask

    initial begin
        int r;
        int r2;
        void'($urandom(32'h5eed));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "tick in reset", int'(sample_tick_o), 0);
        chk("R1", "bit in reset", int'(bit_tick_o), 0);
        chk("R1", "sclk in reset", int'(sclk_o), 0);
        rst_n = 1'b1;
        r = cyc;
        measure("R1", "R3", 0, 64, 0, r, 0);

        // R2/R3: 16-bit divisor with both selects set
        config_run(0, 1, 1, 1, 2, r);
        measure("R6", "R3", 258, 4, 0, r, 0);

        // R2: high byte ignored in 8-bit mode, slow prescale
        config_run(0, 0, 0, 7, 3, r);
        measure("R6", "R3", 3, 64, 0, r, 0);

        // R3: exactly one select set
        config_run(0, 0, 1, 9, 5, r);
        measure("R6", "R3", 5, 16, 0, r, 0);

        // R7: mode change alone restarts
        config_run(0, 0, 0, 0, 6, r);
        repeat (5) @(negedge clk);
        sync_i = 1'b1;
        @(negedge clk);
        r = cyc;
        measure("R7", "R4", 6, 4, 1, r, 0);

        // R4: fast select flipped mid-run in sync mode
        config_run(1, 0, 0, 0, 5, r);
        measure("R6", "R4", 5, 4, 1, r, 1);

        // R6: write exactly on a reload edge
        config_run(1, 0, 1, 0, 5, r);
        while (cyc != r + 12) @(negedge clk);
        lo_wr_i = 1'b1; wdata_i = 8'd5;
        @(negedge clk);
        lo_wr_i = 1'b0;
        r2 = cyc;
        chk("R6", "write edge on reload", r2, r + 13);
        measure("R6", "R4", 5, 4, 1, r2, 0);

        // Random mixes
        for (int i = 0; i < 10; i++) begin
            bit s = 1'($urandom % 2);
            bit w = 1'($urandom % 2);
            bit f = 1'($urandom % 2);
            int lo = int'($urandom % 24);
            int p = exp_scale(s, w, f);
            int hi = (w && p == 64) ? 0 : int'($urandom % 2);
            int d = exp_div(w, hi, lo);
            config_run(s, w, f, hi, lo, r);
            measure("R6", s ? "R4" : "R3", d, p, s, r, 0);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule